// File: doc/BRIEF.md
# Byte-Lane Shared Dual-Port Memory

This block is an on-chip memory with two fully independent access ports that share one clock. One port is meant for a processor-side memory-mapped slave, the other for an external processor or custom logic. Each port has its own address, write data, read data, write strobe, chip select, clock enable and per-byte write enables. No read strobe exists: on every clock edge where its clock enable is high, a port samples its address and returns the stored word one cycle later.

Driving a port's clock enable low freezes that port. Its read data holds even while the address inputs move, and no write from it can land. Writes change only the byte lanes whose enable bit is set. When both ports touch the same word in one cycle, the outcome is defined. A read always returns the word as it was before that cycle's writes. If both ports write the same word, port A takes every lane that both of them enabled.

Top module: `twoport_lane_ram`

## Requirements
- R1: A port whose clock enable is high at a rising edge presents, one cycle later, the word stored at the address sampled on that edge. No read strobe is needed, and chip select does not gate reads.
- R2: While a port's clock enable is low, its read data stays constant whatever its address, write and byte-enable inputs do.
- R3: A port writes only when its write strobe, chip select and clock enable are all high at the same edge. If any of them is low, memory is unchanged.
- R4: Byte-enable bit i covers data bits 8*i+7 down to 8*i. Only the enabled lanes of the addressed word change, and setting every bit writes the whole word in one cycle.
- R5: A port that reads and writes the same address in one cycle returns the word held before that write.
- R6: A port that reads an address the other port writes in the same cycle returns the word held before that write.
- R7: When both ports write one address in the same cycle, port A's byte wins on every lane that both enabled. Every other lane enabled by either port takes that port's byte.
- R8: Reset (rst, active high) drives both read data outputs to zero and keeps them there while it is high. Memory contents survive reset.
- R9: Writes from the two ports to different addresses in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Reset, active high, clears read data registers |
| a_ce | input | 1 | Port A clock enable |
| a_cs | input | 1 | Port A chip select (write qualifier) |
| a_we | input | 1 | Port A write strobe |
| a_be | input | DW/8 | Port A byte-lane write enables |
| a_addr | input | clog2(DEPTH) | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle latency |
| b_ce | input | 1 | Port B clock enable |
| b_cs | input | 1 | Port B chip select (write qualifier) |
| b_we | input | 1 | Port B write strobe |
| b_be | input | DW/8 | Port B byte-lane write enables |
| b_addr | input | clog2(DEPTH) | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle latency |

## Verification
A wrong lane mask or a wrong collision rule leaves a corrupt byte in storage. That byte stays invisible until some port reads the word, and it then shows up one cycle after the read edge. The bench therefore reads back every word it writes and keeps both ports busy in a small address window, so a stale byte is seen within a few cycles. A read register that loads when it should hold, or that reads storage after a same-edge write, shows up on the very next falling edge against the model. A missing reset clear shows up while reset is still high.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int unsigned LANE_BITS = 8;

  function automatic int unsigned lanes_for(input int unsigned width);
    return width / LANE_BITS;
  endfunction
endpackage

// File: rtl/tdp_port_qual.sv
module tdp_port_qual #(
  parameter int unsigned NL = 4
) (
  input  logic          ce,
  input  logic          cs,
  input  logic          we,
  input  logic [NL-1:0] be,
  output logic [NL-1:0] lane_wr
);
  logic wr_ok;

  always_comb begin
    wr_ok   = ce & cs & we;
    lane_wr = {NL{wr_ok}} & be;
  end
endmodule

// File: rtl/tdp_collide.sv
module tdp_collide #(
  parameter int unsigned AW = 8,
  parameter int unsigned NL = 4
) (
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [NL-1:0] a_lane_wr,
  input  logic [NL-1:0] b_lane_wr,
  output logic [NL-1:0] b_lane_ok
);
  logic same_word;

  always_comb begin
    same_word = (a_addr == b_addr);
    b_lane_ok = same_word ? (b_lane_wr & ~a_lane_wr) : b_lane_wr;
  end
endmodule

// File: rtl/tdp_lane_bank.sv
module tdp_lane_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned LW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_ce,
  input  logic [AW-1:0] a_addr,
  input  logic          a_wr,
  input  logic [LW-1:0] a_wd,
  output logic [LW-1:0] a_rd,
  input  logic          b_ce,
  input  logic [AW-1:0] b_addr,
  input  logic          b_wr,
  input  logic [LW-1:0] b_wd,
  output logic [LW-1:0] b_rd
);
  logic [LW-1:0] store [DEPTH];
  logic [LW-1:0] a_rd_d;
  logic [LW-1:0] b_rd_d;

  // storage: collisions are removed upstream, so both writes never hit one word
  always_ff @(posedge clk) begin
    if (a_wr) store[a_addr] <= a_wd;
    if (b_wr) store[b_addr] <= b_wd;
  end

  // next read value: old contents on a write edge, hold when disabled
  always_comb begin
    a_rd_d = a_ce ? store[a_addr] : a_rd;
    b_rd_d = b_ce ? store[b_addr] : b_rd;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      a_rd <= a_rd_d;
      b_rd <= b_rd_d;
    end
  end
endmodule

// File: rtl/twoport_lane_ram.sv
module twoport_lane_ram
  import tdp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     a_ce,
  input  logic                     a_cs,
  input  logic                     a_we,
  input  logic [DW/8-1:0]          a_be,
  input  logic [$clog2(DEPTH)-1:0] a_addr,
  input  logic [DW-1:0]            a_wdata,
  output logic [DW-1:0]            a_rdata,
  input  logic                     b_ce,
  input  logic                     b_cs,
  input  logic                     b_we,
  input  logic [DW/8-1:0]          b_be,
  input  logic [$clog2(DEPTH)-1:0] b_addr,
  input  logic [DW-1:0]            b_wdata,
  output logic [DW-1:0]            b_rdata
);
  localparam int unsigned NL = lanes_for(DW);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [NL-1:0] a_lane_wr;
  logic [NL-1:0] b_lane_wr;
  logic [NL-1:0] b_lane_ok;

  tdp_port_qual #(.NL(NL)) u_qual_a (
    .ce(a_ce), .cs(a_cs), .we(a_we), .be(a_be), .lane_wr(a_lane_wr)
  );

  tdp_port_qual #(.NL(NL)) u_qual_b (
    .ce(b_ce), .cs(b_cs), .we(b_we), .be(b_be), .lane_wr(b_lane_wr)
  );

  tdp_collide #(.AW(AW), .NL(NL)) u_collide (
    .a_addr(a_addr), .b_addr(b_addr),
    .a_lane_wr(a_lane_wr), .b_lane_wr(b_lane_wr),
    .b_lane_ok(b_lane_ok)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    tdp_lane_bank #(.DEPTH(DEPTH), .AW(AW), .LW(LANE_BITS)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .a_ce  (a_ce),
      .a_addr(a_addr),
      .a_wr  (a_lane_wr[g]),
      .a_wd  (a_wdata[g*LANE_BITS +: LANE_BITS]),
      .a_rd  (a_rdata[g*LANE_BITS +: LANE_BITS]),
      .b_ce  (b_ce),
      .b_addr(b_addr),
      .b_wr  (b_lane_ok[g]),
      .b_wd  (b_wdata[g*LANE_BITS +: LANE_BITS]),
      .b_rd  (b_rdata[g*LANE_BITS +: LANE_BITS])
    );
  end
endmodule

// File: rtl/twoport_lane_ram_chk.sv
module twoport_lane_ram_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     a_ce,
  input logic                     a_cs,
  input logic                     a_we,
  input logic [DW/8-1:0]          a_be,
  input logic [$clog2(DEPTH)-1:0] a_addr,
  input logic [DW-1:0]            a_wdata,
  input logic [DW-1:0]            a_rdata,
  input logic                     b_ce,
  input logic                     b_cs,
  input logic                     b_we,
  input logic [DW/8-1:0]          b_be,
  input logic [$clog2(DEPTH)-1:0] b_addr,
  input logic [DW-1:0]            b_wdata,
  input logic [DW-1:0]            b_rdata
);
  logic a_full_wr, b_full_wr, a_any_wr;

  always_comb begin
    a_full_wr = a_we && a_cs && a_ce && (&a_be);
    b_full_wr = b_we && b_cs && b_ce && (&b_be);
    a_any_wr  = a_we && a_cs && a_ce && (|a_be);
  end

  a_r2_hold_a: assert property (@(posedge clk) disable iff (rst)
    !a_ce |=> $stable(a_rdata));

  a_r2_hold_b: assert property (@(posedge clk) disable iff (rst)
    !b_ce |=> $stable(b_rdata));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |-> (a_rdata == '0 && b_rdata == '0));

  // port A full-word write always lands, even against a port B collision (R7)
  a_r4_full_write_a: assert property (@(posedge clk) disable iff (rst)
    a_full_wr ##1 (a_ce && a_addr == $past(a_addr)) |=> a_rdata == $past(a_wdata, 2));

  a_r9_full_write_b: assert property (@(posedge clk) disable iff (rst)
    (b_full_wr && !(a_any_wr && a_addr == b_addr)) ##1 (b_ce && b_addr == $past(b_addr))
      |=> b_rdata == $past(b_wdata, 2));
endmodule

bind twoport_lane_ram twoport_lane_ram_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/twoport_lane_ram_test.sv
module twoport_lane_ram_test;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned NL    = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          a_ce = 0, a_cs = 0, a_we = 0;
  logic [NL-1:0] a_be = '0;
  logic [AW-1:0] a_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic [DW-1:0] a_rdata;
  logic          b_ce = 0, b_cs = 0, b_we = 0;
  logic [NL-1:0] b_be = '0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] b_rdata;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    cmp_on = 0;
  bit    done   = 0;
  string tag    = "R1";

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_a = '0;
  logic [DW-1:0] exp_b = '0;

  always #4 clk = ~clk;

  twoport_lane_ram #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

  // behavioural reference: reads see the word before this edge's writes
  always @(posedge clk) begin
    if (rst) begin
      exp_a = '0;
      exp_b = '0;
    end else begin
      logic [DW-1:0] na, nb;
      na = a_ce ? model[a_addr] : exp_a;
      nb = b_ce ? model[b_addr] : exp_b;
      if (b_we && b_cs && b_ce)
        for (int i = 0; i < NL; i++) if (b_be[i]) model[b_addr][i*8 +: 8] = b_wdata[i*8 +: 8];
      if (a_we && a_cs && a_ce)
        for (int i = 0; i < NL; i++) if (a_be[i]) model[a_addr][i*8 +: 8] = a_wdata[i*8 +: 8];
      exp_a = na;
      exp_b = nb;
    end
  end

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cmp_on) begin
      chk({tag, " port A"}, a_rdata, exp_a);
      chk({tag, " port B"}, b_rdata, exp_b);
    end
  endtask

  task automatic idle();
    a_ce = 0; a_cs = 0; a_we = 0; a_be = '0;
    b_ce = 0; b_cs = 0; b_we = 0; b_be = '0;
  endtask

  task automatic wr_a(input int ad, input logic [NL-1:0] be, input logic [DW-1:0] d);
    a_ce = 1; a_cs = 1; a_we = 1; a_be = be; a_addr = AW'(ad); a_wdata = d;
  endtask

  task automatic rd_a(input int ad);
    a_ce = 1; a_cs = 0; a_we = 0; a_addr = AW'(ad);
  endtask

  initial begin
    #1 rst = 1'b1;
    repeat (3) tick();
    chk("R8 reset A", a_rdata, '0);
    chk("R8 reset B", b_rdata, '0);
    rst = 1'b0;
    // preload every word from port A
    for (int i = 0; i < DEPTH; i++) begin
      wr_a(i, '1, 32'hC0DE0000 + DW'(i));
      tick();
    end
    idle();
    rd_a(0); b_ce = 1; b_addr = '0;
    cmp_on = 1;
    tick();

    tag = "R1"; idle(); rd_a(1);
    tick();
    chk("R1 read latency", a_rdata, 32'hC0DE0001);

    tag = "R2"; a_ce = 0; a_addr = 5; a_cs = 1; a_we = 1; a_be = '1; a_wdata = 32'hDEADBEEF;
    repeat (3) tick();
    chk("R2 hold", a_rdata, 32'hC0DE0001);
    idle(); rd_a(5);
    tick();
    chk("R2 write ignored", a_rdata, 32'hC0DE0005);

    tag = "R3"; wr_a(4, '1, 32'h55555555); a_cs = 0;
    tick();
    wr_a(4, '1, 32'h66666666); a_we = 0;
    tick();
    idle(); rd_a(4);
    tick();
    chk("R3 no write", a_rdata, 32'hC0DE0004);

    tag = "R4"; idle(); wr_a(2, 4'b0101, 32'hFFFFFFFF);
    tick();
    idle(); rd_a(2);
    tick();
    chk("R4 lanes", a_rdata, 32'hC0FF00FF);

    tag = "R5"; idle(); wr_a(6, '1, 32'h12345678);
    tick();
    chk("R5 old word", a_rdata, 32'hC0DE0006);
    idle(); rd_a(6);
    tick();
    chk("R5 new word", a_rdata, 32'h12345678);

    tag = "R6"; idle(); wr_a(7, '1, 32'h0BADF00D); b_ce = 1; b_addr = 7;
    tick();
    chk("R6 cross old", b_rdata, 32'hC0DE0007);
    idle(); b_ce = 1;
    tick();
    chk("R6 cross new", b_rdata, 32'h0BADF00D);

    tag = "R7"; idle(); wr_a(3, 4'b0011, 32'h11111111);
    b_ce = 1; b_cs = 1; b_we = 1; b_be = 4'b0110; b_addr = 3; b_wdata = 32'h22222222;
    tick();
    idle(); rd_a(3);
    tick();
    chk("R7 collision", a_rdata, 32'hC0221111);

    tag = "R9"; idle(); wr_a(8, '1, 32'hAAAA0008);
    b_ce = 1; b_cs = 1; b_we = 1; b_be = '1; b_addr = 9; b_wdata = 32'hBBBB0009;
    tick();
    idle(); rd_a(9); b_ce = 1; b_addr = 8;
    tick();
    chk("R9 A sees B", a_rdata, 32'hBBBB0009);
    chk("R9 B sees A", b_rdata, 32'hAAAA0008);

    tag = "R8"; idle(); rst = 1'b1;
    tick();
    chk("R8 clear during reset", a_rdata, '0);
    rst = 1'b0;
    rd_a(8);
    tick();
    chk("R8 memory kept", a_rdata, 32'hAAAA0008);

    tag = "R7 random";
    for (int c = 0; c < 600; c++) begin
      a_ce = ($urandom % 4) != 0; a_cs = $urandom % 2; a_we = $urandom % 2;
      a_be = NL'($urandom); a_addr = AW'($urandom % 6); a_wdata = $urandom;
      b_ce = ($urandom % 4) != 0; b_cs = $urandom % 2; b_we = $urandom % 2;
      b_be = NL'($urandom); b_addr = AW'($urandom % 6); b_wdata = $urandom;
      tick();
    end
    idle();
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule